// File: doc/BRIEF.md
# Serial Configuration Store Word Reader

This block fetches 16-bit words from a small three-wire serial configuration memory of the common 64- or 256-word family. A host pulses a request with an address. The block frames the access on a select line, a shift clock and a serial command line, and shifts out a read command whose leading start bit is part of the opcode. It then clocks in sixteen data bits from the memory's serial output. When the sequence ends, the block pulses done, and the word stays on the output until the next access finishes.

The memory can answer with either 6 or 8 address bits. A probe request reads word 0 using 8 address bits. The block sets its width flag when that word equals 0x8129, and clears it otherwise. Every later read uses the width the flag selects. A programmable divider sets how many system clocks each half of the shift clock lasts, so one design can serve slow and fast parts.

Top module: `cfg_rom_reader`

## Requirements
- R1: After reset, select, shift clock and command line are low, busy and done are 0, the width flag is 0 (6-bit addressing) and the read word is 0.
- R2: The command is the 3-bit read opcode 110 (start bit first) followed by the address, sent MSB first, 3+W bits in total, where W is the address width. The command bit is set up while the shift clock is low and held for the whole high half.
- R3: An accepted access lasts 42+2W half periods. Select is low for the first half, high from the second half through the last data half, and low in the final half. Done is high for exactly one cycle, and busy falls in that same cycle.
- R4: One half period lasts `half_div` system clocks. A value of 0 acts as 1.
- R5: After the command there is one low half, then 16 clock pulses. The serial input is sampled at the end of each high half and shifted in MSB first. The read word changes only in the cycle done is high.
- R6: When the width flag is 0 a read sends the low 6 address bits and ignores the upper 2. When the flag is 1 it sends all 8.
- R7: A probe reads address 0 with 8 address bits and returns that word. The width flag then becomes 1 if the word equals 0x8129 and 0 otherwise. The flag changes only on a probe's done.
- R8: Requests and probes that arrive while busy are dropped. They start no access and do not alter the word being read.
- R9: If a request and a probe arrive in the same idle cycle, the probe is performed and the request is dropped.
- R10: While not busy, select and shift clock stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | System clocks per shift-clock half period (0 acts as 1) |
| req | input | 1 | Read request, one cycle |
| req_addr | input | 8 | Word address for a read |
| probe | input | 1 | Width probe request, one cycle |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle pulse at the end of an access |
| rdata | output | 16 | Last word read |
| wide | output | 1 | 1 = 8-bit addressing, 0 = 6-bit |
| ee_cs | output | 1 | Memory select |
| ee_sk | output | 1 | Memory shift clock |
| ee_di | output | 1 | Serial command to the memory |
| ee_do | input | 1 | Serial data from the memory |

## Verification
Two pairs of events can land in the same cycle: a read request together with a width probe, and a new request during a running access. The bench raises request and probe on the same edge with a nonzero address. It judges the result by the address and opcode that a behavioural memory model decodes off the pins, and by the returned word and the width flag. It also fires both kinds of request in the middle of an access, then checks that the memory model saw exactly one select rising edge and that the returned word belongs to the first address.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
  localparam int WORD_W      = 16;
  localparam int OPC_W       = 3;
  localparam int ADR_NARROW  = 6;
  localparam int ADR_WIDE    = 8;
  localparam int CMD_W       = OPC_W + ADR_WIDE;
  localparam int CNT_W       = $clog2(WORD_W);

  localparam logic [OPC_W-1:0]  OPC_READ  = 3'b110;
  localparam logic [OPC_W-1:0]  OPC_WRITE = 3'b101;
  localparam logic [OPC_W-1:0]  OPC_ERASE = 3'b111;
  localparam logic [WORD_W-1:0] WIDE_SIGNATURE = 16'h8129;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_PRE,
    PH_SEL,
    PH_CMD_LO,
    PH_CMD_HI,
    PH_GAP,
    PH_DAT_HI,
    PH_DAT_LO,
    PH_END
  } rd_phase_e;
endpackage

// File: rtl/cfg_rom_tick.sv
module cfg_rom_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim_m1;
  logic             at_end;

  assign lim_m1 = (half_div == '0) ? '0 : (half_div - DIV_W'(1));
  assign at_end = (cnt_q >= lim_m1);
  assign tick   = run && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cfg_rom_seq.sv
module cfg_rom_seq
  import cfg_rom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              start_probe,
  input  logic [7:0]        addr,
  input  logic              use_wide,
  input  logic              ee_do,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              fin,
  output logic              fin_probe,
  output logic [WORD_W-1:0] fin_word,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di
);
  rd_phase_e          ph_q, ph_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [CMD_W-1:0]   cmd_q, cmd_d;
  logic [WORD_W-1:0]  sh_q, sh_d;
  logic [WORD_W-1:0]  rd_q, rd_d;
  logic               prb_q, prb_d;
  logic               done_q, done_d;
  logic               cs_q, cs_d, sk_q, sk_d, di_q, di_d;

  assign busy      = (ph_q != PH_IDLE);
  assign done      = done_q;
  assign rdata     = rd_q;
  assign fin       = (ph_q == PH_END) && tick;
  assign fin_probe = prb_q;
  assign fin_word  = sh_q;
  assign ee_cs     = cs_q;
  assign ee_sk     = sk_q;
  assign ee_di     = di_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    cmd_d  = cmd_q;
    sh_d   = sh_q;
    rd_d   = rd_q;
    prb_d  = prb_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_PRE;
          prb_d = start_probe;
          if (use_wide) begin
            cmd_d = {OPC_READ, addr};
            cnt_d = CNT_W'(OPC_W + ADR_WIDE - 1);
          end else begin
            cmd_d = {OPC_READ, addr[ADR_NARROW-1:0], {(ADR_WIDE-ADR_NARROW){1'b0}}};
            cnt_d = CNT_W'(OPC_W + ADR_NARROW - 1);
          end
        end
      end
      PH_PRE:    if (tick) ph_d = PH_SEL;
      PH_SEL:    if (tick) ph_d = PH_CMD_LO;
      PH_CMD_LO: if (tick) ph_d = PH_CMD_HI;
      PH_CMD_HI: begin
        if (tick) begin
          cmd_d = {cmd_q[CMD_W-2:0], 1'b0};
          if (cnt_q == '0) begin
            ph_d = PH_GAP;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
            ph_d  = PH_CMD_LO;
          end
        end
      end
      PH_GAP: begin
        if (tick) begin
          ph_d  = PH_DAT_HI;
          cnt_d = CNT_W'(WORD_W - 1);
        end
      end
      PH_DAT_HI: begin
        if (tick) begin
          sh_d = {sh_q[WORD_W-2:0], ee_do};
          ph_d = PH_DAT_LO;
        end
      end
      PH_DAT_LO: begin
        if (tick) begin
          if (cnt_q == '0) begin
            ph_d = PH_END;
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
            ph_d  = PH_DAT_HI;
          end
        end
      end
      PH_END: begin
        if (tick) begin
          ph_d   = PH_IDLE;
          rd_d   = sh_q;
          done_d = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase

    cs_d = (ph_d != PH_IDLE) && (ph_d != PH_PRE) && (ph_d != PH_END);
    sk_d = (ph_d == PH_CMD_HI) || (ph_d == PH_DAT_HI);
    di_d = ((ph_d == PH_CMD_LO) || (ph_d == PH_CMD_HI)) && cmd_d[CMD_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      cmd_q  <= '0;
      sh_q   <= '0;
      rd_q   <= '0;
      prb_q  <= 1'b0;
      done_q <= 1'b0;
      cs_q   <= 1'b0;
      sk_q   <= 1'b0;
      di_q   <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      cmd_q  <= cmd_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      prb_q  <= prb_d;
      done_q <= done_d;
      cs_q   <= cs_d;
      sk_q   <= sk_d;
      di_q   <= di_d;
    end
  end
endmodule

// File: rtl/cfg_rom_width.sv
module cfg_rom_width
  import cfg_rom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              wide
);
  logic wide_q, wide_d;

  assign wide = wide_q;

  always_comb begin
    wide_d = wide_q;
    if (load) wide_d = (word == WIDE_SIGNATURE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wide_q <= 1'b0;
    else        wide_q <= wide_d;
  end
endmodule

// File: rtl/cfg_rom_reader.sv
module cfg_rom_reader
  import cfg_rom_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              req,
  input  logic [7:0]        req_addr,
  input  logic              probe,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic              wide,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  logic              tick;
  logic              start;
  logic [7:0]        start_addr;
  logic              start_wide;
  logic              fin, fin_probe;
  logic [WORD_W-1:0] fin_word;

  assign start      = (req || probe) && !busy;
  assign start_addr = probe ? 8'h00 : req_addr;
  assign start_wide = probe ? 1'b1 : wide;

  cfg_rom_tick #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .half_div (half_div),
    .tick     (tick)
  );

  cfg_rom_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .start       (start),
    .start_probe (probe),
    .addr        (start_addr),
    .use_wide    (start_wide),
    .ee_do       (ee_do),
    .busy        (busy),
    .done        (done),
    .rdata       (rdata),
    .fin         (fin),
    .fin_probe   (fin_probe),
    .fin_word    (fin_word),
    .ee_cs       (ee_cs),
    .ee_sk       (ee_sk),
    .ee_di       (ee_di)
  );

  cfg_rom_width u_width (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fin && fin_probe),
    .word  (fin_word),
    .wide  (wide)
  );
endmodule

// File: rtl/cfg_rom_reader_chk.sv
module cfg_rom_reader_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        probe,
  input logic        busy,
  input logic        done,
  input logic [15:0] rdata,
  input logic        wide,
  input logic        ee_cs,
  input logic        ee_sk,
  input logic        ee_di
);
  p_idle_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ee_cs && !ee_sk));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_sk_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |-> ee_cs);

  p_di_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  p_wide_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wide) |-> done);

  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(rdata));

  p_start_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req || probe));
endmodule

bind cfg_rom_reader cfg_rom_reader_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .req   (req),
  .probe (probe),
  .busy  (busy),
  .done  (done),
  .rdata (rdata),
  .wide  (wide),
  .ee_cs (ee_cs),
  .ee_sk (ee_sk),
  .ee_di (ee_di)
);

// File: tb/sim_cfg_rom_reader.sv
`timescale 1ns/1ps
module sim_cfg_rom_reader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  half_div = 8'd1;
  logic        req = 1'b0;
  logic [7:0]  req_addr = 8'h00;
  logic        probe = 1'b0;
  logic        busy, done, wide, ee_cs, ee_sk, ee_di;
  logic [15:0] rdata;
  logic        ee_do;

  int n_checks = 0;
  int n_errors = 0;

  always #4 clk = ~clk;

  cfg_rom_reader #(.DIV_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .req(req),
    .req_addr(req_addr), .probe(probe), .busy(busy), .done(done),
    .rdata(rdata), .wide(wide), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do)
  );

  // behavioural memory model
  int          m_alen = 6;
  logic [15:0] m_w0 = 16'h0000;
  int          m_cnt = 0;
  int          m_acc = 0;
  logic [10:0] m_cmd = '0;
  logic [2:0]  m_op = '0;
  int          m_addr = 0;
  logic [15:0] m_word = '0;
  logic        m_do = 1'b1;
  assign ee_do = m_do;

  function automatic logic [15:0] word_of(input int a, input logic [15:0] w0);
    logic [15:0] v;
    if (a == 0) return w0;
    v = 16'(a * 1297) ^ 16'hA55A;
    return v + 16'(a);
  endfunction

  always @(posedge ee_cs) begin
    m_cnt = 0;
    m_cmd = '0;
    m_do  = 1'b1;
    m_acc = m_acc + 1;
  end

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      if (m_cnt < 3 + m_alen) begin
        m_cmd = {m_cmd[9:0], ee_di};
        if (m_cnt == 3 + m_alen - 1) begin
          m_op   = 3'(m_cmd >> m_alen);
          m_addr = int'(m_cmd) & ((1 << m_alen) - 1);
          m_word = word_of(m_addr, m_w0);
        end
      end else begin
        int k;
        k = m_cnt - (3 + m_alen);
        m_do = (k < 16) ? m_word[15 - k] : 1'b0;
      end
      m_cnt = m_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input logic [7:0] a, input logic pr, input logic rq,
                        output int cyc);
    @(negedge clk);
    req = rq; probe = pr; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; probe = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(150000 * 8);
    n_checks++; n_errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    int cyc;
    int acc0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk({ee_cs, ee_sk, ee_di} == 3'b000, "R1", "pins", {ee_cs, ee_sk, ee_di}, 0);
    chk(!busy && !done, "R1", "busy/done", {busy, done}, 0);
    chk(!wide, "R1", "width flag", wide, 0);
    chk(rdata == 16'h0, "R1", "rdata", rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R5: full 6-bit sweep, one clock per half
    m_alen = 6;
    for (int a = 0; a < 64; a++) begin
      access(8'(a), 1'b0, 1'b1, cyc);
      chk(rdata == word_of(a, m_w0), "R5", "word", rdata, word_of(a, m_w0));
      chk(m_op == 3'b110, "R2", "opcode", m_op, 3'b110);
      chk(m_addr == a, "R2", "address", m_addr, a);
      chk(m_cnt == 3 + 6 + 16, "R3", "clock pulses", m_cnt, 25);
      chk(cyc == 54, "R3", "length", cyc, 54);
      chk(!busy, "R3", "busy after done", busy, 0);
    end

    // R6: upper address bits ignored in 6-bit mode
    access(8'hC5, 1'b0, 1'b1, cyc);
    chk(m_addr == 5, "R6", "masked address", m_addr, 5);
    chk(rdata == word_of(5, m_w0), "R6", "masked word", rdata, word_of(5, m_w0));

    // R4: half period length
    for (int hd = 0; hd < 5; hd++) begin
      int lim;
      half_div = 8'(hd);
      lim = (hd == 0) ? 1 : hd;
      access(8'h2A, 1'b0, 1'b1, cyc);
      chk(cyc == 54 * lim, "R4", "access cycles", cyc, 54 * lim);
      chk(rdata == word_of(42, m_w0), "R4", "word", rdata, word_of(42, m_w0));
    end
    half_div = 8'd1;

    // R7: probes
    m_alen = 8;
    m_w0 = 16'h8128;
    access(8'h33, 1'b1, 1'b0, cyc);
    chk(m_addr == 0, "R7", "probe address", m_addr, 0);
    chk(cyc == 58, "R7", "probe length", cyc, 58);
    chk(rdata == 16'h8128, "R7", "probe word", rdata, 16'h8128);
    chk(!wide, "R7", "near-signature", wide, 0);
    m_w0 = 16'h8129;
    access(8'h00, 1'b1, 1'b0, cyc);
    chk(wide, "R7", "signature", wide, 1);

    // R6: 8-bit sweep
    for (int a = 0; a < 256; a++) begin
      access(8'(a), 1'b0, 1'b1, cyc);
      chk(m_addr == a, "R6", "wide address", m_addr, a);
      chk(rdata == word_of(a, m_w0), "R6", "wide word", rdata, word_of(a, m_w0));
      chk(cyc == 58, "R3", "wide length", cyc, 58);
    end
    chk(wide, "R7", "flag kept by reads", wide, 1);

    // R8: requests during busy ignored
    acc0 = m_acc;
    @(negedge clk);
    req = 1'b1; req_addr = 8'h11;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    repeat (10) @(negedge clk);
    req = 1'b1; probe = 1'b1; req_addr = 8'h77;
    @(negedge clk);
    req = 1'b0; probe = 1'b0;
    cyc = 0;
    while (!done && cyc < 1000) begin @(negedge clk); cyc++; end
    chk(rdata == word_of(17, m_w0), "R8", "word of first address", rdata, word_of(17, m_w0));
    repeat (100) @(negedge clk);
    chk(m_acc == acc0 + 1, "R8", "accesses", m_acc, acc0 + 1);
    chk(!busy, "R8", "busy", busy, 0);
    chk(wide, "R8", "width flag", wide, 1);
    // R10: idle pins
    chk(!ee_cs && !ee_sk, "R10", "idle pins", {ee_cs, ee_sk}, 0);

    // R9: request and probe together, probe wins
    m_w0 = 16'h0000;
    access(8'h05, 1'b1, 1'b1, cyc);
    chk(m_addr == 0, "R9", "address", m_addr, 0);
    chk(rdata == 16'h0000, "R9", "word", rdata, 0);
    chk(!wide, "R9", "width flag", wide, 0);
    chk(cyc == 58, "R9", "probe length", cyc, 58);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule